// File: doc/BRIEF.md
# Endpoint Buffer Command Access Controller

This block gives a 16-bit microprocessor bus access to sixteen USB device endpoint buffers through one-byte command codes. A command selects a direction and a buffer. Each command also sets the buffer pointer back to the start of that buffer. The data strobes that follow then move one 16-bit word each, and the pointer advances on its own by two byte addresses. Word 0 of every buffer holds the packet length in bytes. In DMA mode the pointer starts past that word, so only the payload is moved.

Buffer 0 is the control OUT buffer and buffer 1 is the control IN buffer. Buffers 2 to 15 belong to data endpoints 1 to 14. The packet engine fills buffers through a separate deposit port. On the IN side, the block raises a per-buffer ready flag once a buffer is completely filled. In DMA mode an external end-of-transfer input also raises the flag, at whatever fill level the buffer has reached. On a DMA read, the block works out the last payload word from the stored length, flags it with an end-of-packet marker and stops the transfer there. Misuse of the bus gives defined results: a strobe in the wrong direction sets a sticky error flag, accesses past the buffer end are harmless, and unknown codes do nothing.

Top module: `ep_cmd_port`

## Requirements
- R1: A low `rst_n`, or command code F6h, clears the pointer, all ready flags, the error flag, `rd_valid` and the current operation. Buffer contents are kept.
- R2: Codes 01h to 0Fh select a write to buffer `code[3:0]`. Code 01h is the control IN buffer (1), and 02h to 0Fh are endpoints 1 to 14 (buffers 2 to 15).
- R3: Codes 10h and 12h to 1Fh select a read from buffer `code[3:0]`. Code 10h is control OUT (buffer 0). Reads return the words that were stored.
- R4: Each read or write command sets `buf_ptr` to byte 0, or to byte 2 when `dma_mode` is high in that cycle.
- R5: Each accepted data word advances `buf_ptr` by 2.
- R6: A buffer holds WORDS = M+1 words, with M = (BUF_BYTES+1)/2. A write at or past word WORDS is discarded. A read there returns 0 with `rd_valid`. The pointer holds in both cases.
- R7: In DMA mode word 0 (the length) is neither read nor written by data strobes.
- R8: A write to word M sets `buf_ready` for the selected buffer. A new write command to that buffer clears the flag.
- R9: `eot` high during a DMA write operation sets `buf_ready` for the selected buffer at any fill level.
- R10: On a DMA read, the last word index is (L+1)/2, where L is word 0, limited to the range 1 to M. That word comes out with `rd_eop`. Later reads return 0 and the pointer holds.
- R11: A read strobe during a write operation, or a write strobe during a read operation, is ignored and sets `proto_err`. The flag stays set until the next reset (R1).
- R12: Codes other than 01h to 10h, 12h to 1Fh and F6h change no state. Data strobes in a command cycle are ignored.
- R13: `rd_data`, `rd_valid` and `rd_eop` are registered and appear one clock after `rd_en` during a read operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command byte |
| dma_mode | input | 1 | DMA access mode, sampled with the command |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 16 | Data word to write |
| rd_en | input | 1 | Data read strobe |
| rd_data | output | 16 | Word read, one cycle after strobe |
| rd_valid | output | 1 | Read response valid |
| rd_eop | output | 1 | Last payload word of a DMA read |
| eot | input | 1 | External end of transfer |
| pkt_we | input | 1 | Packet-engine deposit strobe |
| pkt_buf | input | 4 | Deposit buffer index |
| pkt_word | input | $clog2(M+1) | Deposit word index |
| pkt_data | input | 16 | Deposit word |
| buf_ptr | output | $clog2(M+2)+1 | Current buffer byte pointer |
| buf_ready | output | 16 | Per-buffer IN ready flags |
| proto_err | output | 1 | Sticky direction error |

## Verification
The assertions check several rules on every cycle: the reset command clears state, the pointer start position after each command, that the pointer only steps by two, the upper bound on the pointer, that unknown codes leave all state stable, that the error flag is sticky, and the timing of read responses and end-of-packet. Several behaviours can only be shown by the bench's scenarios against its reference model: which buffer each code selects, the data returned, the ready flags on a full buffer and on `eot`, and the end-of-packet position derived from the stored length.

// File: rtl/ep_cmd_port.sv
module ep_cmd_port #(
  parameter int BUF_BYTES = 64
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cmd_valid,
  input  logic [7:0]                         cmd_code,
  input  logic                               dma_mode,
  input  logic                               wr_en,
  input  logic [15:0]                        wr_data,
  input  logic                               rd_en,
  output logic [15:0]                        rd_data,
  output logic                               rd_valid,
  output logic                               rd_eop,
  input  logic                               eot,
  input  logic                               pkt_we,
  input  logic [3:0]                         pkt_buf,
  input  logic [$clog2((BUF_BYTES+1)/2+1)-1:0] pkt_word,
  input  logic [15:0]                        pkt_data,
  output logic [$clog2((BUF_BYTES+1)/2+2):0] buf_ptr,
  output logic [15:0]                        buf_ready,
  output logic                               proto_err
);
  localparam int NBUF  = 16;
  localparam int M     = (BUF_BYTES + 1) / 2;
  localparam int WORDS = M + 1;
  localparam int AW    = $clog2(WORDS);
  localparam int WW    = $clog2(WORDS + 1);
  localparam logic [7:0] CMD_RESET = 8'hF6;

  typedef enum logic [1:0] {OP_IDLE, OP_WR, OP_RD} op_t;

  logic [15:0]   mem [NBUF][WORDS];
  op_t           op_q;
  logic [3:0]    idx_q;
  logic [WW-1:0] ptr_q, last_q;
  logic          dma_q, done_q;

  wire is_wr  = cmd_valid && cmd_code[7:4] == 4'h0 && cmd_code[3:0] != 4'h0;
  wire is_rd  = cmd_valid && cmd_code[7:4] == 4'h1 && cmd_code[3:0] != 4'h1;
  wire is_rst = cmd_valid && cmd_code == CMD_RESET;

  wire in_range = ptr_q < WW'(WORDS);
  wire wr_ok    = !cmd_valid && wr_en && op_q == OP_WR && in_range;
  wire rd_act   = !cmd_valid && rd_en && op_q == OP_RD;
  wire rd_ok    = rd_act && in_range && !done_q;
  wire bad_dir  = !cmd_valid && ((wr_en && op_q == OP_RD) || (rd_en && op_q == OP_WR));
  wire eot_hit  = !cmd_valid && eot && op_q == OP_WR && dma_q;
  wire [AW-1:0] addr = ptr_q[AW-1:0];

  wire [15:0] len_word = mem[cmd_code[3:0]][0];
  wire [16:0] len_words = ({1'b0, len_word} + 17'd1) >> 1;
  wire [WW-1:0] last_w = (len_words == 17'd0) ? WW'(1) :
                         (len_words > 17'(M)) ? WW'(M) : len_words[WW-1:0];
  wire [WW-1:0] start_w = dma_mode ? WW'(1) : WW'(0);

  assign buf_ptr = {ptr_q, 1'b0};

  always_ff @(posedge clk) begin
    if (pkt_we && pkt_word < AW'(WORDS))
      mem[pkt_buf][pkt_word] <= pkt_data;
    if (wr_ok)
      mem[idx_q][addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= OP_IDLE;
      idx_q     <= '0;
      ptr_q     <= '0;
      last_q    <= '0;
      dma_q     <= 1'b0;
      done_q    <= 1'b0;
      buf_ready <= '0;
      proto_err <= 1'b0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      rd_eop    <= 1'b0;
    end else if (is_rst) begin
      op_q      <= OP_IDLE;
      idx_q     <= '0;
      ptr_q     <= '0;
      last_q    <= '0;
      dma_q     <= 1'b0;
      done_q    <= 1'b0;
      buf_ready <= '0;
      proto_err <= 1'b0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      rd_eop    <= 1'b0;
    end else begin
      rd_valid <= rd_act;
      rd_data  <= rd_ok ? mem[idx_q][addr] : 16'h0;
      rd_eop   <= rd_ok && dma_q && ptr_q == last_q;
      if (is_wr || is_rd) begin
        op_q   <= is_wr ? OP_WR : OP_RD;
        idx_q  <= cmd_code[3:0];
        ptr_q  <= start_w;
        dma_q  <= dma_mode;
        done_q <= 1'b0;
        last_q <= last_w;
        if (is_wr) buf_ready[cmd_code[3:0]] <= 1'b0;
      end else begin
        if (bad_dir) proto_err <= 1'b1;
        if (wr_ok) begin
          ptr_q <= ptr_q + 1'b1;
          if (ptr_q == WW'(M)) buf_ready[idx_q] <= 1'b1;
        end
        if (eot_hit) buf_ready[idx_q] <= 1'b1;
        if (rd_ok) begin
          ptr_q <= ptr_q + 1'b1;
          if (dma_q && ptr_q == last_q) done_q <= 1'b1;
        end
      end
    end
  end
endmodule

module ep_cmd_port_chk #(
  parameter int BUF_BYTES = 64
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               cmd_valid,
  input logic [7:0]                         cmd_code,
  input logic                               dma_mode,
  input logic                               rd_en,
  input logic                               rd_valid,
  input logic                               rd_eop,
  input logic [$clog2((BUF_BYTES+1)/2+2):0] buf_ptr,
  input logic [15:0]                        buf_ready,
  input logic                               proto_err
);
  localparam int WORDS = (BUF_BYTES + 1) / 2 + 1;
  localparam int PW = $clog2(WORDS + 1) + 1;

  wire rst_cmd = cmd_valid && cmd_code == 8'hF6;
  wire rw_cmd  = cmd_valid && ((cmd_code >= 8'h01 && cmd_code <= 8'h10) ||
                               (cmd_code >= 8'h12 && cmd_code <= 8'h1F));
  wire unk_cmd = cmd_valid && !rw_cmd && !rst_cmd;

  assert_reset_cmd_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> buf_ptr == '0 && buf_ready == '0 && !proto_err && !rd_valid);

  assert_ptr_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rw_cmd |=> buf_ptr == ($past(dma_mode) ? PW'(2) : PW'(0)));

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (buf_ptr == $past(buf_ptr) || buf_ptr == $past(buf_ptr) + PW'(2)));

  assert_ptr_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ptr <= PW'(2 * WORDS));

  assert_unknown_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    unk_cmd |=> $stable(buf_ptr) && $stable(buf_ready) && $stable(proto_err));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err && !rst_cmd |=> proto_err);

  assert_read_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));

  assert_eop_with_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_eop |-> rd_valid);
endmodule

bind ep_cmd_port ep_cmd_port_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (.*);

// File: tb/sim_ep_cmd_port.sv
module sim_ep_cmd_port;
  localparam int CLK_PERIOD = 10;
  localparam int BUF_BYTES = 64;
  localparam int M = (BUF_BYTES + 1) / 2;
  localparam int WORDS = M + 1;
  localparam int AW = $clog2(WORDS);
  localparam int PW = $clog2(WORDS + 1) + 1;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, dma_mode = 0, wr_en = 0, rd_en = 0, eot = 0, pkt_we = 0;
  logic [7:0] cmd_code = 0;
  logic [15:0] wr_data = 0, pkt_data = 0;
  logic [3:0] pkt_buf = 0;
  logic [AW-1:0] pkt_word = 0;
  logic [15:0] rd_data, buf_ready;
  logic rd_valid, rd_eop, proto_err;
  logic [PW-1:0] buf_ptr;

  int nchk = 0, nerr = 0;
  bit run = 0;

  ep_cmd_port #(.BUF_BYTES(BUF_BYTES)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int lenv(int b);
    return b == 0 ? 10 : b == 3 ? 1000 : b * 3;
  endfunction
  function automatic int pat(int b, int w);
    return w == 0 ? lenv(b) : (b << 8) | w;
  endfunction

  // behavioural reference model
  int m_mem [16][WORDS];
  int m_op, m_idx, m_ptr, m_last, m_rd;
  bit m_dma, m_done, m_err, m_rv, m_re;
  bit [15:0] m_ready;

  task automatic m_clear();
    m_op = 0; m_idx = 0; m_ptr = 0; m_last = 0; m_dma = 0; m_done = 0;
    m_err = 0; m_rv = 0; m_re = 0; m_rd = 0; m_ready = '0;
  endtask

  initial begin
    foreach (m_mem[b, w]) m_mem[b][w] = 0;
    m_clear();
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_clear();
    else begin
      int c, len, wds;
      bit rv, re; int rdv;
      rv = 0; re = 0; rdv = 0;
      if (pkt_we && int'(pkt_word) < WORDS) m_mem[pkt_buf][pkt_word] = pkt_data;
      c = cmd_code;
      if (cmd_valid) begin
        if (c == 'hF6) m_clear();
        else if ((c >= 1 && c <= 15) || c == 16 || (c >= 18 && c <= 31)) begin
          m_op = c < 16 ? 1 : 2;
          m_idx = c % 16;
          m_ptr = dma_mode ? 1 : 0;
          m_dma = dma_mode; m_done = 0;
          len = m_mem[m_idx][0];
          wds = (len + 1) / 2;
          m_last = wds == 0 ? 1 : wds > M ? M : wds;
          if (m_op == 1) m_ready[m_idx] = 0;
        end
        m_rv = 0; m_re = 0; m_rd = 0;
        if (c != 'hF6) m_rv = 0;
      end else begin
        if ((wr_en && m_op == 2) || (rd_en && m_op == 1)) m_err = 1;
        if (wr_en && m_op == 1 && m_ptr < WORDS) begin
          m_mem[m_idx][m_ptr] = wr_data;
          if (m_ptr == M) m_ready[m_idx] = 1;
          m_ptr++;
        end
        if (eot && m_op == 1 && m_dma) m_ready[m_idx] = 1;
        if (rd_en && m_op == 2) begin
          rv = 1;
          if (m_ptr < WORDS && !m_done) begin
            rdv = m_mem[m_idx][m_ptr];
            if (m_dma && m_ptr == m_last) begin re = 1; m_done = 1; end
            m_ptr++;
          end
        end
        m_rv = rv; m_re = re; m_rd = rdv;
      end
    end
  end

  // R13: every output compared with the model each cycle
  always @(negedge clk) begin
    if (run && rst_n) begin
      nchk++;
      if (rd_valid !== m_rv || rd_eop !== m_re || (m_rv && rd_data !== 16'(m_rd)) ||
          buf_ptr !== PW'(2 * m_ptr) || buf_ready !== m_ready || proto_err !== m_err) begin
        nerr++;
        $display("FAIL R13 model @%0t: act v=%0b e=%0b d=%h p=%0d r=%h err=%0b exp v=%0b e=%0b d=%h p=%0d r=%h err=%0b",
          $time, rd_valid, rd_eop, rd_data, buf_ptr, buf_ready, proto_err,
          m_rv, m_re, 16'(m_rd), 2 * m_ptr, m_ready, m_err);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] c);
    cmd_valid = 1; cmd_code = c; @(negedge clk); cmd_valid = 0;
  endtask
  task automatic wr(input logic [15:0] d);
    wr_en = 1; wr_data = d; @(negedge clk); wr_en = 0;
  endtask
  task automatic rd();
    rd_en = 1; @(negedge clk); rd_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; run = 1;
    @(negedge clk);
    chk("R1 reset ptr", int'(buf_ptr), 0);
    chk("R1 reset ready", int'(buf_ready), 0);
    chk("R1 reset err", int'(proto_err), 0);

    for (int b = 0; b < 16; b++)
      for (int w = 0; w < WORDS; w++) begin
        pkt_we = 1; pkt_buf = 4'(b); pkt_word = AW'(w); pkt_data = 16'(pat(b, w));
        @(negedge clk);
      end
    pkt_we = 0;

    // R3 control OUT read
    cmd(8'h10);
    for (int i = 0; i < 3; i++) begin
      rd();
      chk("R3 ctrl OUT data", int'(rd_data), pat(0, i));
      chk("R13 rd_valid", int'(rd_valid), 1);
    end
    chk("R5 ptr after 3 reads", int'(buf_ptr), 6);

    // R2 control IN and endpoint 1
    cmd(8'h01);
    chk("R4 ptr reset", int'(buf_ptr), 0);
    wr(16'hA001); wr(16'hA002);
    chk("R5 ptr after writes", int'(buf_ptr), 4);
    cmd(8'h02); wr(16'hB001); wr(16'hB002);
    cmd(8'h12); rd();
    chk("R2 ep1 readback 0", int'(rd_data), 'hB001);
    rd();
    chk("R2 ep1 readback 1", int'(rd_data), 'hB002);

    // R6 R8 fill and overrun
    cmd(8'h05);
    for (int i = 0; i < WORDS; i++) begin
      if (i == WORDS - 1) chk("R8 not ready before full", int'(buf_ready[5]), 0);
      wr(16'(16'h5000 + i));
    end
    chk("R8 ready on full", int'(buf_ready[5]), 1);
    wr(16'hDEAD); wr(16'hBEEF);
    chk("R6 ptr holds on overrun write", int'(buf_ptr), 2 * WORDS);
    cmd(8'h15);
    for (int i = 0; i < WORDS; i++) begin
      rd();
      if (rd_data !== 16'(16'h5000 + i)) chk("R6 full readback", int'(rd_data), 'h5000 + i);
    end
    rd();
    chk("R6 overrun read zero", int'(rd_data), 0);
    chk("R6 overrun read valid", int'(rd_valid), 1);
    chk("R6 overrun ptr", int'(buf_ptr), 2 * WORDS);
    cmd(8'h05);
    chk("R8 ready cleared by new write cmd", int'(buf_ready[5]), 0);

    // R7 R10 DMA read
    dma_mode = 1;
    cmd(8'h16);
    chk("R7 dma start ptr", int'(buf_ptr), 2);
    for (int i = 1; i <= 9; i++) begin
      rd();
      chk("R7 dma data", int'(rd_data), pat(6, i));
      chk("R10 eop position", int'(rd_eop), i == 9 ? 1 : 0);
    end
    rd();
    chk("R10 read after eop zero", int'(rd_data), 0);
    chk("R10 ptr holds after eop", int'(buf_ptr), 20);
    cmd(8'h13);
    for (int i = 1; i <= M; i++) begin
      rd();
      if (i == M) chk("R10 eop clamped to M", int'(rd_eop), 1);
    end
    cmd(8'h10); rd(); rd(); rd(); rd(); rd();
    chk("R10 ctrl OUT eop at word 5", int'(rd_eop), 1);

    // R9 early release
    cmd(8'h07);
    wr(16'h7001); wr(16'h7002); wr(16'h7003);
    chk("R9 not ready before eot", int'(buf_ready[7]), 0);
    eot = 1; @(negedge clk); eot = 0;
    chk("R9 ready on eot", int'(buf_ready[7]), 1);

    // R11 direction errors
    rd();
    chk("R11 wrong-direction read no valid", int'(rd_valid), 0);
    chk("R11 error set", int'(proto_err), 1);
    dma_mode = 0;
    cmd(8'h12);
    chk("R11 error sticky", int'(proto_err), 1);
    wr(16'hFFFF);
    chk("R11 wrong-direction write ptr", int'(buf_ptr), 0);
    rd();
    chk("R11 wrong write not stored", int'(rd_data), 'hB001);

    // R1 reset command
    cmd(8'hF6);
    chk("R1 F6 err", int'(proto_err), 0);
    chk("R1 F6 ready", int'(buf_ready), 0);
    chk("R1 F6 ptr", int'(buf_ptr), 0);

    // R12 unknown codes
    cmd(8'h04); wr(16'h4000); wr(16'h4001);
    cmd(8'h11); cmd(8'h00); cmd(8'h20); cmd(8'hF7); cmd(8'hFF);
    chk("R12 ptr unchanged", int'(buf_ptr), 4);
    wr(16'h4002);
    cmd(8'h14); rd(); rd(); rd();
    chk("R12 write continued", int'(rd_data), 'h4002);

    // R1 hardware reset keeps contents
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R1 hw reset ptr", int'(buf_ptr), 0);
    cmd(8'h14); rd();
    chk("R1 contents kept", int'(rd_data), 'h4000);

    run = 0;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule